// File: doc/BRIEF.md
# Rotating Register Window Controller

This block keeps the bookkeeping state of a windowed general register file: the current window base, counted in groups of four physical registers, and a live-frame bitmap with one bit per group. Each cycle it accepts at most one window operation (rotate, call entry, windowed return, stack-move check, overflow check, base write, base restore). It updates the base and bitmap, or raises one window exception. An exception carries a size class, and the controller saves the pre-exception base so that a handler can restore it later.

The physical registers and the spill/fill handlers sit outside. For a call entry the controller only computes the destination register index and value that the register file must write. For a return it produces the return PC. Every result is registered, so it appears on the outputs one clock after the operation is presented.

Top module: `wrf_window_ctrl`

## Requirements
- R1: After reset, windowBase is 0, windowStart has only bit 0 set, savedBase is 0, excmFlag is 0 and excKind is 0 (none).
- R2: Opcode 1 (rotate) adds rotImm, read as a signed 4-bit value, to windowBase modulo the group count. windowStart is left unchanged.
- R3: Opcode 2 (entry) adds callInc to windowBase and sets the windowStart bit of the new base. It issues a register write to index {callInc, srcIdx[1:0]} with value srcVal minus entryImm.
- R4: Opcode 3 (return) takes n = retWord[31:30]. On a legal return without underflow it subtracts n from windowBase, clears the windowStart bit of the old base, and outputs retPc = {curPc[31:30], retWord[29:0]} with retValid. windowStart never becomes all zero.
- R5: A return is illegal when n is 0. It is also illegal when m is nonzero and differs from n, where m is the first distance of 1, 2 or 3 below the base (searched in that order) whose windowStart bit is set. An illegal return raises kind 7, captures curPc in excPc, and leaves windowBase and windowStart unchanged. Legality is judged before underflow.
- R6: A legal return whose windowStart bit at base-n is clear underflows. It subtracts n from windowBase, keeps windowStart, loads savedBase with the old base, captures curPc, and raises kind 4, 5 or 6 for n of 1, 2 or 3.
- R7: Opcode 5 (overflow check, window size w = rotImm[1:0]) computes d as the distance from the base to the first set windowStart bit above it, with wraparound. When d is at most w, it adds d to windowBase and loads savedBase with the old base. It then raises kind 1, 2 or 3 when the next set bit above the new base is at distance 1, 2, or 3 or more. Otherwise nothing changes.
- R8: Opcode 4 (stack-move check) raises kind 8 when the windowStart bits at base-1, base-2 and base-3 are all clear. Otherwise it has no effect.
- R9: Opcode 6 loads windowBase with wrData modulo the group count. Opcode 7 loads windowBase from savedBase and clears excmFlag.
- R10: Any raised exception sets excmFlag, which stays set until opcode 7. excKind shows the raised kind for exactly one cycle and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | Operation present this cycle |
| opCode | input | 3 | Operation select |
| rotImm | input | 4 | Signed rotate amount; low two bits are the overflow window size |
| callInc | input | 2 | Call increment for entry |
| retWord | input | 32 | Return-address word holding n in bits 31:30 |
| curPc | input | 32 | PC of the current operation |
| wrData | input | 32 | Value for a base write |
| srcIdx | input | 4 | Entry source register index |
| srcVal | input | 32 | Entry source register value |
| entryImm | input | 32 | Entry frame-size immediate |
| windowBase | output | BASE_W | Current window base |
| windowStart | output | GROUPS | Live-frame bitmap |
| savedBase | output | BASE_W | Base saved by the last window exception |
| excmFlag | output | 1 | Exception-mode flag |
| excKind | output | 4 | Raised exception kind, 0 when none |
| excPc | output | 32 | PC captured on an exception |
| retPc | output | 32 | Computed return PC |
| retValid | output | 1 | retPc produced this cycle |
| regWrEn | output | 1 | Register write request from entry |
| regWrIdx | output | 4 | Register write index |
| regWrData | output | 32 | Register write value |

## Verification
The properties assume that opValid is a clean level, low during reset, and that the opcode and operands are stable for the whole cycle in which opValid is high. The bitmap-never-empty property also assumes that operations start from the reset bitmap, because no input can load windowStart directly. The bench drives every operand on the falling edge, lowers opValid after exactly one operation cycle, and reaches every bitmap pattern through entry and return sequences that begin from reset.

// File: rtl/wrf_pkg.sv
package wrf_pkg;

  typedef enum logic [2:0] {
    OP_NOP     = 3'd0,
    OP_ROTATE  = 3'd1,
    OP_ENTRY   = 3'd2,
    OP_RETURN  = 3'd3,
    OP_STKMOVE = 3'd4,
    OP_OVFCHK  = 3'd5,
    OP_WRBASE  = 3'd6,
    OP_RESTORE = 3'd7
  } wrf_op_e;

  typedef enum logic [3:0] {
    EXC_NONE    = 4'd0,
    EXC_OVF4    = 4'd1,
    EXC_OVF8    = 4'd2,
    EXC_OVF12   = 4'd3,
    EXC_UNF4    = 4'd4,
    EXC_UNF8    = 4'd5,
    EXC_UNF12   = 4'd6,
    EXC_ILLEGAL = 4'd7,
    EXC_ALLOCA  = 4'd8
  } wrf_exc_e;

  typedef struct packed {
    logic     loadBase;
    logic     setStart;
    logic     clrStart;
    logic     raise;
    logic     saveOld;
    logic     clearExcm;
    logic     loadRet;
    logic     regWrite;
    wrf_exc_e kind;
  } wrf_strobe_t;

endpackage

// File: rtl/wrf_ctrl.sv
module wrf_ctrl
  import wrf_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int BASE_W = 4
) (
  input  logic              opValid,
  input  wrf_op_e           opCode,
  input  logic [3:0]        rotImm,
  input  logic [1:0]        callInc,
  input  logic [1:0]        retN,
  input  logic [31:0]       wrData,
  input  logic [BASE_W-1:0] curBase,
  input  logic [BASE_W-1:0] oldBase,
  input  logic [GROUPS-1:0] curStart,
  output wrf_strobe_t       strb,
  output logic [BASE_W-1:0] nextBase,
  output logic [BASE_W-1:0] startIdx
);

  localparam int DBL_W = 2 * GROUPS;
  localparam int DIST_W = BASE_W + 1;

  // distance from 'start' (inclusive) to the first set bit, wrapping; GROUPS if none
  function automatic logic [DIST_W-1:0] firstFrom(input logic [GROUPS-1:0] v,
                                                  input logic [BASE_W-1:0] start);
    logic [DBL_W-1:0] dbl;
    logic [DIST_W-1:0] d;
    dbl = {v, v} >> start;
    d = DIST_W'(GROUPS);
    for (int k = GROUPS - 1; k >= 0; k--) begin
      if (dbl[k]) d = DIST_W'(k);
    end
    return d;
  endfunction

  logic signed [7:0]  rotWide;
  logic [BASE_W-1:0]  rotDelta;
  logic [1:0]         nearM;
  logic               retIllegal;
  logic               retUnder;
  logic [DIST_W-1:0]  ovfDist;
  logic               ovfHit;
  logic [BASE_W-1:0]  ovfBase;
  logic [DIST_W-1:0]  nextDist;
  wrf_exc_e           ovfKind;
  wrf_exc_e           unfKind;

  assign rotWide  = 8'(signed'(rotImm));
  assign rotDelta = rotWide[BASE_W-1:0];

  always_comb begin
    if (curStart[curBase - BASE_W'(1)])      nearM = 2'd1;
    else if (curStart[curBase - BASE_W'(2)]) nearM = 2'd2;
    else if (curStart[curBase - BASE_W'(3)]) nearM = 2'd3;
    else                                     nearM = 2'd0;
  end

  assign retIllegal = (retN == 2'd0) || ((nearM != 2'd0) && (nearM != retN));
  assign retUnder   = !curStart[curBase - BASE_W'(retN)];
  assign unfKind    = (retN == 2'd1) ? EXC_UNF4 : (retN == 2'd2) ? EXC_UNF8 : EXC_UNF12;

  assign ovfDist  = firstFrom(curStart, curBase + BASE_W'(1));
  assign ovfHit   = (ovfDist != DIST_W'(GROUPS)) &&
                    ((ovfDist + DIST_W'(1)) <= DIST_W'(rotImm[1:0]));
  assign ovfBase  = curBase + ovfDist[BASE_W-1:0] + BASE_W'(1);
  assign nextDist = firstFrom(curStart, ovfBase + BASE_W'(1));
  assign ovfKind  = (nextDist == '0) ? EXC_OVF4 :
                    (nextDist == DIST_W'(1)) ? EXC_OVF8 : EXC_OVF12;

  always_comb begin
    strb      = '0;
    strb.kind = EXC_NONE;
    nextBase  = curBase;
    startIdx  = curBase;
    if (opValid) begin
      case (opCode)
        OP_ROTATE: begin
          strb.loadBase = 1'b1;
          nextBase      = curBase + rotDelta;
        end
        OP_ENTRY: begin
          strb.loadBase = 1'b1;
          strb.setStart = 1'b1;
          strb.regWrite = 1'b1;
          nextBase      = curBase + BASE_W'(callInc);
          startIdx      = curBase + BASE_W'(callInc);
        end
        OP_RETURN: begin
          if (retIllegal) begin
            strb.raise = 1'b1;
            strb.kind  = EXC_ILLEGAL;
          end else if (retUnder) begin
            strb.loadBase = 1'b1;
            strb.saveOld  = 1'b1;
            strb.raise    = 1'b1;
            strb.kind     = unfKind;
            nextBase      = curBase - BASE_W'(retN);
          end else begin
            strb.loadBase = 1'b1;
            strb.clrStart = 1'b1;
            strb.loadRet  = 1'b1;
            nextBase      = curBase - BASE_W'(retN);
          end
        end
        OP_STKMOVE: begin
          if (nearM == 2'd0) begin
            strb.raise = 1'b1;
            strb.kind  = EXC_ALLOCA;
          end
        end
        OP_OVFCHK: begin
          if (ovfHit) begin
            strb.loadBase = 1'b1;
            strb.saveOld  = 1'b1;
            strb.raise    = 1'b1;
            strb.kind     = ovfKind;
            nextBase      = ovfBase;
          end
        end
        OP_WRBASE: begin
          strb.loadBase = 1'b1;
          nextBase      = wrData[BASE_W-1:0];
        end
        OP_RESTORE: begin
          strb.loadBase  = 1'b1;
          strb.clearExcm = 1'b1;
          nextBase       = oldBase;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wrf_dpath.sv
module wrf_dpath
  import wrf_pkg::*;
#(
  parameter int GROUPS = 16,
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrf_strobe_t       strb,
  input  logic [BASE_W-1:0] nextBase,
  input  logic [BASE_W-1:0] startIdx,
  input  logic [31:0]       curPc,
  input  logic [31:0]       retWord,
  input  logic [1:0]        callInc,
  input  logic [3:0]        srcIdx,
  input  logic [31:0]       srcVal,
  input  logic [31:0]       entryImm,
  output logic [BASE_W-1:0] baseQ,
  output logic [GROUPS-1:0] startQ,
  output logic [BASE_W-1:0] oldQ,
  output logic              excmQ,
  output wrf_exc_e          kindQ,
  output logic [31:0]       excPcQ,
  output logic [31:0]       retPcQ,
  output logic              retValidQ,
  output logic              regWrEnQ,
  output logic [3:0]        regWrIdxQ,
  output logic [31:0]       regWrDataQ
);

  genvar g;
  generate
    for (g = 0; g < GROUPS; g++) begin : g_start
      localparam logic RST_BIT = (g == 0);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          startQ[g] <= RST_BIT;
        end else if (startIdx == BASE_W'(g)) begin
          if (strb.setStart)      startQ[g] <= 1'b1;
          else if (strb.clrStart) startQ[g] <= 1'b0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ      <= '0;
      oldQ       <= '0;
      excmQ      <= 1'b0;
      kindQ      <= EXC_NONE;
      excPcQ     <= '0;
      retPcQ     <= '0;
      retValidQ  <= 1'b0;
      regWrEnQ   <= 1'b0;
      regWrIdxQ  <= '0;
      regWrDataQ <= '0;
    end else begin
      kindQ     <= strb.raise ? strb.kind : EXC_NONE;
      retValidQ <= strb.loadRet;
      regWrEnQ  <= strb.regWrite;
      if (strb.loadBase) baseQ <= nextBase;
      if (strb.saveOld)  oldQ  <= baseQ;
      if (strb.raise) begin
        excmQ  <= 1'b1;
        excPcQ <= curPc;
      end else if (strb.clearExcm) begin
        excmQ <= 1'b0;
      end
      if (strb.loadRet) retPcQ <= {curPc[31:30], retWord[29:0]};
      if (strb.regWrite) begin
        regWrIdxQ  <= {callInc, srcIdx[1:0]};
        regWrDataQ <= srcVal - entryImm;
      end
    end
  end

endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl
  import wrf_pkg::*;
#(
  parameter int NUM_PHYS_REGS = 64,
  localparam int GROUPS = NUM_PHYS_REGS / 4,
  localparam int BASE_W = $clog2(GROUPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [3:0]        rotImm,
  input  logic [1:0]        callInc,
  input  logic [31:0]       retWord,
  input  logic [31:0]       curPc,
  input  logic [31:0]       wrData,
  input  logic [3:0]        srcIdx,
  input  logic [31:0]       srcVal,
  input  logic [31:0]       entryImm,
  output logic [BASE_W-1:0] windowBase,
  output logic [GROUPS-1:0] windowStart,
  output logic [BASE_W-1:0] savedBase,
  output logic              excmFlag,
  output logic [3:0]        excKind,
  output logic [31:0]       excPc,
  output logic [31:0]       retPc,
  output logic              retValid,
  output logic              regWrEn,
  output logic [3:0]        regWrIdx,
  output logic [31:0]       regWrData
);

  wrf_strobe_t       strb;
  logic [BASE_W-1:0] nextBase;
  logic [BASE_W-1:0] startIdx;
  wrf_exc_e          kindQ;

  wrf_ctrl #(.GROUPS(GROUPS), .BASE_W(BASE_W)) u_ctrl (
    .opValid (opValid),
    .opCode  (wrf_op_e'(opCode)),
    .rotImm  (rotImm),
    .callInc (callInc),
    .retN    (retWord[31:30]),
    .wrData  (wrData),
    .curBase (windowBase),
    .oldBase (savedBase),
    .curStart(windowStart),
    .strb    (strb),
    .nextBase(nextBase),
    .startIdx(startIdx)
  );

  wrf_dpath #(.GROUPS(GROUPS), .BASE_W(BASE_W)) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .nextBase  (nextBase),
    .startIdx  (startIdx),
    .curPc     (curPc),
    .retWord   (retWord),
    .callInc   (callInc),
    .srcIdx    (srcIdx),
    .srcVal    (srcVal),
    .entryImm  (entryImm),
    .baseQ     (windowBase),
    .startQ    (windowStart),
    .oldQ      (savedBase),
    .excmQ     (excmFlag),
    .kindQ     (kindQ),
    .excPcQ    (excPc),
    .retPcQ    (retPc),
    .retValidQ (retValid),
    .regWrEnQ  (regWrEn),
    .regWrIdxQ (regWrIdx),
    .regWrDataQ(regWrData)
  );

  assign excKind = kindQ;

endmodule

// File: rtl/wrf_window_sva.sv
module wrf_window_sva #(
  parameter int GROUPS = 16,
  parameter int BASE_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              opValid,
  input logic [2:0]        opCode,
  input logic [3:0]        rotImm,
  input logic [31:0]       retWord,
  input logic [BASE_W-1:0] windowBase,
  input logic [GROUPS-1:0] windowStart,
  input logic [BASE_W-1:0] savedBase,
  input logic              excmFlag,
  input logic [3:0]        excKind,
  input logic              regWrEn
);

  logic signed [7:0]  rotExt;
  logic [BASE_W-1:0]  rotStep;
  assign rotExt  = 8'(signed'(rotImm));
  assign rotStep = rotExt[BASE_W-1:0];

  a_r1_start_never_empty: assert property (@(posedge clk) disable iff (!rstN)
    windowStart != '0);

  a_r2_rotate_moves_base: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd1) |=>
      (windowBase == BASE_W'($past(windowBase) + $past(rotStep))) && $stable(windowStart));

  a_r3_entry_marks_frame: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd2) |=> windowStart[windowBase] && regWrEn);

  a_r4_return_shifts_base: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd3) |=>
      (excKind != 4'd0) ||
      (windowBase == BASE_W'($past(windowBase) - BASE_W'($past(retWord[31:30])))));

  a_r5_zero_n_illegal: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && opCode == 3'd3 && retWord[31:30] == 2'd0) |=>
      (excKind == 4'd7) && $stable(windowBase) && $stable(windowStart));

  a_r6_saves_old_base: assert property (@(posedge clk) disable iff (!rstN)
    (excKind >= 4'd1 && excKind <= 4'd6) |-> savedBase == $past(windowBase));

  a_r10_kind_pulse: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> excKind == 4'd0);

  a_r10_excm_with_kind: assert property (@(posedge clk) disable iff (!rstN)
    (excKind != 4'd0) |-> excmFlag);

endmodule

bind wrf_window_ctrl wrf_window_sva #(.GROUPS(GROUPS), .BASE_W(BASE_W)) u_sva (
  .clk        (clk),
  .rstN       (rstN),
  .opValid    (opValid),
  .opCode     (opCode),
  .rotImm     (rotImm),
  .retWord    (retWord),
  .windowBase (windowBase),
  .windowStart(windowStart),
  .savedBase  (savedBase),
  .excmFlag   (excmFlag),
  .excKind    (excKind),
  .regWrEn    (regWrEn)
);

// File: tb/wrf_window_ctrl_tb.sv
module wrf_window_ctrl_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        opValid = 1'b0;
  logic [2:0]  opCode = '0;
  logic [3:0]  rotImm = '0;
  logic [1:0]  callInc = '0;
  logic [31:0] retWord = '0;
  logic [31:0] curPc = '0;
  logic [31:0] wrData = '0;
  logic [3:0]  srcIdx = '0;
  logic [31:0] srcVal = '0;
  logic [31:0] entryImm = '0;

  logic [3:0]  windowBase;
  logic [15:0] windowStart;
  logic [3:0]  savedBase;
  logic        excmFlag;
  logic [3:0]  excKind;
  logic [31:0] excPc;
  logic [31:0] retPc;
  logic        retValid;
  logic        regWrEn;
  logic [3:0]  regWrIdx;
  logic [31:0] regWrData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  wrf_window_ctrl u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode), .rotImm(rotImm),
    .callInc(callInc), .retWord(retWord), .curPc(curPc), .wrData(wrData),
    .srcIdx(srcIdx), .srcVal(srcVal), .entryImm(entryImm),
    .windowBase(windowBase), .windowStart(windowStart), .savedBase(savedBase),
    .excmFlag(excmFlag), .excKind(excKind), .excPc(excPc), .retPc(retPc),
    .retValid(retValid), .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrData(regWrData)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    opValid = 1'b0;
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  // inputs set by caller at a falling edge; results visible at the next falling edge
  task automatic fire(input logic [2:0] op);
    opCode = op;
    opValid = 1'b1;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  task automatic doEntry(input logic [1:0] ci);
    callInc = ci;
    fire(3'd2);
  endtask

  task automatic doWrBase(input logic [31:0] v);
    wrData = v;
    fire(3'd6);
  endtask

  task automatic doReturn(input logic [1:0] n, input logic [29:0] tgt, input logic [31:0] pc);
    retWord = {n, tgt};
    curPc = pc;
    fire(3'd3);
  endtask

  task automatic testReset();
    doReset();
    chk("R1", "base", 32'(windowBase), 32'h0);
    chk("R1", "start", 32'(windowStart), 32'h0001);
    chk("R1", "saved", 32'(savedBase), 32'h0);
    chk("R1", "excm", 32'(excmFlag), 32'h0);
    chk("R1", "kind", 32'(excKind), 32'h0);
  endtask

  task automatic testRotate();
    doReset();
    rotImm = 4'd3;
    fire(3'd1);
    chk("R2", "rotate +3 base", 32'(windowBase), 32'd3);
    chk("R2", "rotate +3 start", 32'(windowStart), 32'h0001);
    rotImm = 4'b1011;
    fire(3'd1);
    chk("R2", "rotate -5 wraps", 32'(windowBase), 32'd14);
    doWrBase(32'h25);
    chk("R9", "write base masked", 32'(windowBase), 32'd5);
  endtask

  task automatic testEntryReturn();
    doReset();
    srcIdx = 4'd1; srcVal = 32'd100; entryImm = 32'd16;
    doEntry(2'd1);
    chk("R3", "entry base", 32'(windowBase), 32'd1);
    chk("R3", "entry start", 32'(windowStart), 32'h0003);
    chk("R3", "entry wr en", 32'(regWrEn), 32'd1);
    chk("R3", "entry wr idx", 32'(regWrIdx), 32'd5);
    chk("R3", "entry wr data", regWrData, 32'd84);
    srcIdx = 4'd5; srcVal = 32'd7; entryImm = 32'd9;
    doEntry(2'd2);
    chk("R3", "entry2 base", 32'(windowBase), 32'd3);
    chk("R3", "entry2 start", 32'(windowStart), 32'h000B);
    chk("R3", "entry2 wr idx", 32'(regWrIdx), 32'd9);
    chk("R3", "entry2 wr data", regWrData, 32'hFFFF_FFFE);
    doReturn(2'd2, 30'h123, 32'hC000_0040);
    chk("R4", "return base", 32'(windowBase), 32'd1);
    chk("R4", "return start", 32'(windowStart), 32'h0003);
    chk("R4", "return pc", retPc, 32'hC000_0123);
    chk("R4", "return valid", 32'(retValid), 32'd1);
    chk("R4", "no exception", 32'(excKind), 32'd0);
    doReturn(2'd1, 30'h2000_0ABC, 32'h4000_0000);
    chk("R4", "return2 base", 32'(windowBase), 32'd0);
    chk("R4", "return2 start", 32'(windowStart), 32'h0001);
    chk("R4", "return2 pc", retPc, 32'h6000_0ABC);
  endtask

  task automatic testIllegal();
    doReset();
    doReturn(2'd0, 30'h10, 32'h0000_0500);
    chk("R5", "n=0 kind", 32'(excKind), 32'd7);
    chk("R5", "n=0 base", 32'(windowBase), 32'd0);
    chk("R5", "n=0 start", 32'(windowStart), 32'h0001);
    chk("R5", "n=0 pc", excPc, 32'h0000_0500);
    chk("R10", "excm set", 32'(excmFlag), 32'd1);
    @(negedge clk);
    chk("R10", "kind one cycle", 32'(excKind), 32'd0);
    chk("R10", "excm sticky", 32'(excmFlag), 32'd1);
    doReset();
    doEntry(2'd1);
    doReturn(2'd2, 30'h0, 32'h0000_0600);
    chk("R5", "m!=n kind", 32'(excKind), 32'd7);
    chk("R5", "m!=n base", 32'(windowBase), 32'd1);
    chk("R5", "m!=n start", 32'(windowStart), 32'h0003);
  endtask

  task automatic testUnderflow();
    for (int n = 1; n <= 3; n++) begin
      doReset();
      doReturn(2'(n), 30'h0, 32'h0000_0700 + 32'(n));
      chk("R6", "underflow kind", 32'(excKind), 32'(3 + n));
      chk("R6", "underflow base", 32'(windowBase), 32'(16 - n));
      chk("R6", "underflow start", 32'(windowStart), 32'h0001);
      chk("R6", "underflow pc", excPc, 32'h0000_0700 + 32'(n));
    end
    doReset();
    doWrBase(32'd5);
    doReturn(2'd1, 30'h0, 32'h0000_0800);
    chk("R6", "underflow from 5 kind", 32'(excKind), 32'd4);
    chk("R6", "underflow from 5 base", 32'(windowBase), 32'd4);
    chk("R6", "saved base", 32'(savedBase), 32'd5);
    fire(3'd7);
    chk("R9", "restore base", 32'(windowBase), 32'd5);
    chk("R9", "restore clears excm", 32'(excmFlag), 32'd0);
  endtask

  task automatic testOverflow();
    doReset();
    doEntry(2'd1);
    doEntry(2'd1);
    doWrBase(32'd14);
    rotImm = 4'd1; curPc = 32'h0000_0900;
    fire(3'd5);
    chk("R7", "out of window kind", 32'(excKind), 32'd0);
    chk("R7", "out of window base", 32'(windowBase), 32'd14);
    rotImm = 4'd3;
    fire(3'd5);
    chk("R7", "ovf4 kind", 32'(excKind), 32'd1);
    chk("R7", "ovf4 base", 32'(windowBase), 32'd0);
    chk("R7", "ovf4 saved", 32'(savedBase), 32'd14);
    chk("R7", "ovf4 pc", excPc, 32'h0000_0900);
    doReset();
    doEntry(2'd2);
    doWrBase(32'd14);
    rotImm = 4'd2;
    fire(3'd5);
    chk("R7", "ovf8 kind", 32'(excKind), 32'd2);
    chk("R7", "ovf8 base", 32'(windowBase), 32'd0);
    doReset();
    doEntry(2'd3);
    doWrBase(32'd14);
    rotImm = 4'd3;
    fire(3'd5);
    chk("R7", "ovf12 kind", 32'(excKind), 32'd3);
    chk("R7", "ovf12 start", 32'(windowStart), 32'h0009);
  endtask

  task automatic testStackMove();
    doReset();
    curPc = 32'h0000_0A00;
    fire(3'd4);
    chk("R8", "alloca kind", 32'(excKind), 32'd8);
    chk("R8", "alloca pc", excPc, 32'h0000_0A00);
    doReset();
    doEntry(2'd1);
    fire(3'd4);
    chk("R8", "no alloca kind", 32'(excKind), 32'd0);
    chk("R8", "no alloca excm", 32'(excmFlag), 32'd0);
    chk("R8", "no alloca base", 32'(windowBase), 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    testReset();
    testRotate();
    testEntryReturn();
    testIllegal();
    testUnderflow();
    testOverflow();
    testStackMove();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule